// File: doc/BRIEF.md
# Serial Character Transmitter with Timed Break

This block shifts 8-bit characters onto a single serial line. Each character is framed by a low start bit and one or two high stop bits. An optional parity bit, even or odd, sits between the data and the stop bits. Bit timing comes from a one-cycle `baud_tick` strobe supplied from outside: every bit lasts exactly one tick period. A one-entry holding register lets software queue the next byte while the current one is still shifting, so consecutive characters go out with no idle gap.

The block can also drive a break (a sustained low level) in two ways. With `lin_mode` low, the break lasts for as long as the break control bit stays set, and software ends it with `brk_clr`. With `lin_mode` high, the block times the break itself from the 2-bit `brk_len` field. When the break ends, the block clears the control bit, sends the selected number of stop bits, and pulses `brk_done`. In either mode, setting the break pulls the line low on the next cycle and drops any character in progress.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, and whenever nothing is queued, `txd` is high, `tx_empty` is high, `busy` is low and `brk_active` is low.
- R2: A frame is one low start bit, then data bits 0 through 7 in that order (least significant first). Each bit lasts one `baud_tick` period. A queued byte starts on the first tick edge after it is available.
- R3: With `par_en` high, one parity bit follows bit 7. Its value is the XOR of the 8 data bits, XORed with `par_odd`: 0 selects even parity and 1 selects odd parity. With `par_en` low, no parity bit is sent.
- R4: `two_stop` low gives one high stop bit and `two_stop` high gives two. A byte queued before the last stop bit ends starts its start bit immediately after that stop bit.
- R5: A `brk_set` pulse makes `brk_active` high and `txd` low in the next cycle. It aborts any character in progress, and the aborted character is never resent.
- R6: With `lin_mode` low, the break and `brk_active` last until a `brk_clr` pulse. No stop bits are added afterwards, and `txd` is high two cycles after the clear.
- R7: With `lin_mode` high, the break lasts exactly 13 + `brk_len` tick edges counted from break entry, giving 13, 14, 15 or 16 bit times.
- R8: With `lin_mode` high, `brk_active` clears by itself when the timed break ends, and `brk_clr` is ignored.
- R9: After a timed break, the line is held high for one stop bit (`two_stop` low) or two stop bits (`two_stop` high), counted in tick periods.
- R10: A byte written during a timed break, or during its trailing stop bits, is held and starts right after the last stop bit.
- R11: `brk_done` goes high for exactly one clock cycle at the end of each timed break sequence.
- R12: `tx_empty` is low while a byte is held or being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe marking each bit boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to queue |
| par_en | input | 1 | Adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| lin_mode | input | 1 | 1 selects hardware-timed break |
| brk_set | input | 1 | Pulse that sets the break control bit |
| brk_clr | input | 1 | Pulse that clears the break control bit (standard mode only) |
| brk_len | input | 2 | Timed break length, added to 13 bit times |
| txd | output | 1 | Serial line, idles high |
| tx_empty | output | 1 | Holding register and shifter both empty |
| busy | output | 1 | Sequencer is not idle |
| brk_active | output | 1 | Break control bit |
| brk_done | output | 1 | One-cycle pulse when a timed break sequence completes |

## Verification
Characters go out in back-to-back pairs for every combination of parity enable, parity sense and stop count. The byte values vary so that each data position and both parity results occur. The slot after the last stop bit tells one stop bit from two, because the queued second byte's start bit must land exactly there. The timed break is run for all four lengths with both stop counts. Low-level tick edges are counted to separate the four lengths, and high-level tick edges are counted to separate the stop counts. A byte is queued during some of the breaks, and `brk_clr` is pulsed during one of them to show that it has no effect in that mode. A standard-mode break is placed over a character of all-ones, so the drop to low shows the abort at once. The break is held well past 16 ticks to show it does not time out, and no resend may follow its release.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_BSTOP
    } seq_state_t;
endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (take_i) nxt_d.full = 1'b0;
        if (wr_i) begin
            nxt_d.full = 1'b1;
            nxt_d.data = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign full_o = cur_q.full;
    assign data_o = cur_q.data;

    // The sequencer only consumes a byte that is actually held (R12)
    assert_take_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> cur_q.full);
endmodule

// File: rtl/uart_brk_ctl.sv
module uart_brk_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic lin_i,
    input  logic hw_clr_i,
    output logic brk_o
);
    typedef struct packed {
        logic brk;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (set_i)                          nxt_d.brk = 1'b1;
        else if (hw_clr_i || (clr_i && !lin_i)) nxt_d.brk = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign brk_o = cur_q.brk;

    // Software clear has no effect while the break is hardware timed (R8)
    assert_lin_clr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.brk && lin_i && clr_i && !hw_clr_i) |=> cur_q.brk);
endmodule

// File: rtl/uart_brk_seq.sv
module uart_brk_seq
    import uart_brk_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 2,
    parameter int BRK_BASE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    input  logic              lin_i,
    input  logic              brk_i,
    input  logic [LEN_W-1:0]  brk_len_i,
    output logic              take_o,
    output logic              hw_clr_o,
    output logic              line_o,
    output logic              idle_o,
    output logic              done_o
);
    localparam int BRK_CW = $clog2(BRK_BASE + (1 << LEN_W) + 1);
    localparam int DAT_CW = $clog2(DATA_W + 1);
    localparam int CNT_W  = (BRK_CW > DAT_CW) ? BRK_CW : DAT_CW;

    typedef struct packed {
        seq_state_t        state;
        logic [DATA_W-1:0] shf;
        logic [CNT_W-1:0]  cnt;
        logic              line;
        logic              par;
        logic              pen;
        logic              two;
        logic              done;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic finish;
    logic [CNT_W-1:0] brk_total;
    logic [CNT_W-1:0] cnt_inc;

    assign brk_total = CNT_W'(BRK_BASE) + CNT_W'(brk_len_i);
    assign cnt_inc   = CNT_W'(cur_q.cnt + 1'b1);

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        take_o     = 1'b0;
        hw_clr_o   = 1'b0;
        finish     = 1'b0;
        if (brk_i && cur_q.state != ST_BRK) begin
            nxt_d.state = ST_BRK;
            nxt_d.line  = 1'b0;
            nxt_d.cnt   = '0;
        end else begin
            case (cur_q.state)
                ST_IDLE: begin
                    nxt_d.line = 1'b1;
                    if (tick_i) finish = 1'b1;
                end
                ST_START: if (tick_i) begin
                    nxt_d.state = ST_DATA;
                    nxt_d.line  = cur_q.shf[0];
                    nxt_d.shf   = cur_q.shf >> 1;
                    nxt_d.cnt   = '0;
                end
                ST_DATA: if (tick_i) begin
                    if (cur_q.cnt == CNT_W'(DATA_W - 1)) begin
                        if (cur_q.pen) begin
                            nxt_d.state = ST_PAR;
                            nxt_d.line  = cur_q.par;
                        end else begin
                            nxt_d.state = ST_STOP;
                            nxt_d.line  = 1'b1;
                            nxt_d.cnt   = '0;
                        end
                    end else begin
                        nxt_d.line = cur_q.shf[0];
                        nxt_d.shf  = cur_q.shf >> 1;
                        nxt_d.cnt  = cnt_inc;
                    end
                end
                ST_PAR: if (tick_i) begin
                    nxt_d.state = ST_STOP;
                    nxt_d.line  = 1'b1;
                    nxt_d.cnt   = '0;
                end
                ST_STOP: if (tick_i) begin
                    if (cur_q.two && cur_q.cnt == '0) nxt_d.cnt = CNT_W'(1);
                    else                              finish = 1'b1;
                end
                ST_BRK: begin
                    nxt_d.line = 1'b0;
                    if (!brk_i) begin
                        nxt_d.state = ST_IDLE;
                        nxt_d.line  = 1'b1;
                    end else if (lin_i && tick_i) begin
                        if (cnt_inc == brk_total) begin
                            nxt_d.state = ST_BSTOP;
                            nxt_d.line  = 1'b1;
                            nxt_d.cnt   = '0;
                            nxt_d.two   = two_stop_i;
                            hw_clr_o    = 1'b1;
                        end else begin
                            nxt_d.cnt = cnt_inc;
                        end
                    end
                end
                ST_BSTOP: if (tick_i) begin
                    if (cur_q.two && cur_q.cnt == '0) begin
                        nxt_d.cnt = CNT_W'(1);
                    end else begin
                        finish     = 1'b1;
                        nxt_d.done = 1'b1;
                    end
                end
                default: begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.line  = 1'b1;
                end
            endcase
            if (finish) begin
                if (hold_full_i) begin
                    nxt_d.state = ST_START;
                    nxt_d.line  = 1'b0;
                    nxt_d.shf   = hold_data_i;
                    nxt_d.pen   = par_en_i;
                    nxt_d.par   = (^hold_data_i) ^ par_odd_i;
                    nxt_d.two   = two_stop_i;
                    take_o      = 1'b1;
                end else begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.line  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
            cur_q.line  <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign line_o = cur_q.line;
    assign idle_o = (cur_q.state == ST_IDLE);
    assign done_o = cur_q.done;

    // Data bit index never runs past the character width (R2)
    assert_data_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_DATA) |-> (cur_q.cnt < CNT_W'(DATA_W)));

    // Timed break counter stays below the programmed length (R7)
    assert_brk_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_BRK && lin_i && $stable(brk_len_i)) |-> (cur_q.cnt < brk_total));
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 2,
    parameter int BRK_BASE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              lin_mode,
    input  logic              brk_set,
    input  logic              brk_clr,
    input  logic [LEN_W-1:0]  brk_len,
    output logic              txd,
    output logic              tx_empty,
    output logic              busy,
    output logic              brk_active,
    output logic              brk_done
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              hw_clr;
    logic              seq_line;
    logic              seq_idle;
    logic              seq_done;
    logic              brk_q;

    uart_brk_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_en),
        .wr_data_i (wr_data),
        .take_i    (take),
        .full_o    (hold_full),
        .data_o    (hold_data)
    );

    uart_brk_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (brk_set),
        .clr_i    (brk_clr),
        .lin_i    (lin_mode),
        .hw_clr_i (hw_clr),
        .brk_o    (brk_q)
    );

    uart_brk_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .BRK_BASE(BRK_BASE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (baud_tick),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .par_en_i    (par_en),
        .par_odd_i   (par_odd),
        .two_stop_i  (two_stop),
        .lin_i       (lin_mode),
        .brk_i       (brk_q),
        .brk_len_i   (brk_len),
        .take_o      (take),
        .hw_clr_o    (hw_clr),
        .line_o      (seq_line),
        .idle_o      (seq_idle),
        .done_o      (seq_done)
    );

    assign txd        = seq_line & ~brk_q;
    assign tx_empty   = ~hold_full & seq_idle;
    assign busy       = ~seq_idle;
    assign brk_active = brk_q;
    assign brk_done   = seq_done;

    // A newly set break takes over the sequencer one cycle later (R5)
    assert_brk_takes_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_active) |=> busy);

    // Completion strobe is a single cycle wide (R11)
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done |=> !brk_done);

    // Completion only follows a cleared break bit (R8)
    assert_done_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done |-> !$past(brk_active));

    // End of a timed break leads into trailing stop bits, not idle (R9)
    assert_lin_stop_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(brk_active) && lin_mode && $stable(lin_mode)) |-> busy);
endmodule

// File: tb/sim_uart_brk_tx.sv
module sim_uart_brk_tx;
    localparam int CLK_P = 10;
    localparam int TP    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, lin_mode = 1'b0;
    logic       brk_set = 1'b0, brk_clr = 1'b0;
    logic [1:0] brk_len = 2'd0;
    logic       txd, tx_empty, busy, brk_active, brk_done;

    int n_chk = 0;
    int n_err = 0;
    int done_seen = 0;

    uart_brk_tx u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .lin_mode(lin_mode),
        .brk_set(brk_set), .brk_clr(brk_clr), .brk_len(brk_len),
        .txd(txd), .tx_empty(tx_empty), .busy(busy), .brk_active(brk_active),
        .brk_done(brk_done)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #1;
            tick = (ph == TP - 1);
            ph = (ph + 1) % TP;
        end
    end

    always @(negedge clk) if (brk_done === 1'b1) done_seen++;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        report();
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit do_wr);
        for (int j = 0; j < TP; j++) begin
            @(negedge clk);
            if (do_wr) wr_en = (j == 0);
        end
        wr_en = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] v);
        @(negedge clk);
        wr_data = v;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        int guard = 0;
        while (txd !== 1'b0 && guard < 20 * TP) begin
            @(negedge clk);
            guard++;
        end
        chk("R2 start seen", int'(txd), 0);
    endtask

    // Called at the first cycle of a start bit
    task automatic check_frame(input logic [7:0] d, input bit pen, input bit podd,
                               input bit two, input bit next_start,
                               input bit wr_next, input logic [7:0] wr_val);
        chk("R2 start bit", int'(txd), 0);
        if (wr_next) wr_data = wr_val;
        for (int i = 0; i < 8; i++) begin
            step(wr_next && i == 0);
            chk($sformatf("R2 data bit %0d of %02h", i, d), int'(txd), int'(d[i]));
        end
        if (pen) begin
            step(1'b0);
            chk($sformatf("R3 parity of %02h odd=%0d", d, podd), int'(txd), int'((^d) ^ podd));
        end
        step(1'b0);
        chk("R4 first stop", int'(txd), 1);
        if (two) begin
            step(1'b0);
            chk("R4 second stop", int'(txd), 1);
        end
        step(1'b0);
        chk($sformatf("R4 slot after stop next=%0d", next_start), int'(txd), next_start ? 0 : 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset tx_empty", int'(tx_empty), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset brk_active", int'(brk_active), 0);
        chk("R11 reset brk_done", int'(brk_done), 0);

        // Framing sweep: every parity/stop configuration, back-to-back pairs
        for (int cfg = 0; cfg < 8; cfg++) begin
            par_en   = cfg[0];
            par_odd  = cfg[1];
            two_stop = cfg[2];
            for (int k = 0; k < 5; k++) begin
                logic [7:0] a, b;
                a = 8'((k * 53 + cfg * 29 + 8'h1B) & 8'hFF);
                b = a ^ 8'hA5;
                if (k == 0) a = 8'h00;
                if (k == 1) b = 8'hFF;
                write_byte(a);
                chk("R12 tx_empty low with byte held", int'(tx_empty), 0);
                wait_start();
                check_frame(a, cfg[0], cfg[1], cfg[2], 1'b1, 1'b1, b);
                check_frame(b, cfg[0], cfg[1], cfg[2], 1'b0, 1'b0, 8'h00);
                repeat (TP) @(negedge clk);
                chk("R1 idle tx_empty", int'(tx_empty), 1);
                chk("R1 idle txd", int'(txd), 1);
            end
        end

        // Standard-mode break over an all-ones character
        par_en = 1'b0; two_stop = 1'b0; lin_mode = 1'b0;
        write_byte(8'hFF);
        wait_start();
        repeat (3 * TP) @(negedge clk);
        chk("R5 pre-break data high", int'(txd), 1);
        brk_set = 1'b1;
        @(negedge clk);
        brk_set = 1'b0;
        chk("R5 line low next cycle", int'(txd), 0);
        chk("R5 brk_active set", int'(brk_active), 1);
        begin
            int highs = 0;
            for (int c = 0; c < 25 * TP; c++) begin
                @(negedge clk);
                if (txd !== 1'b0) highs++;
            end
            chk("R6 held low without timeout", highs, 0);
        end
        chk("R6 brk_active still set", int'(brk_active), 1);
        brk_clr = 1'b1;
        @(negedge clk);
        brk_clr = 1'b0;
        @(negedge clk);
        chk("R6 line high after clear", int'(txd), 1);
        chk("R6 brk_active cleared", int'(brk_active), 0);
        begin
            int lows = 0;
            for (int c = 0; c < 4 * TP; c++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk("R5 aborted byte not resent", lows, 0);
        end
        chk("R1 empty after standard break", int'(tx_empty), 1);

        // Timed breaks: all lengths, both stop counts
        lin_mode = 1'b1;
        for (int len = 0; len < 4; len++) begin
            for (int two = 0; two < 2; two++) begin
                bit          hold;
                logic [7:0]  val;
                int          low_ticks, hi_ticks, it;
                hold = (len % 2 == 1);
                val  = 8'(8'h3C + len * 17 + two);
                brk_len = 2'(len);
                two_stop = two[0];
                done_seen = 0;
                brk_set = 1'b1;
                @(negedge clk);
                brk_set = 1'b0;
                low_ticks = 0;
                it = 0;
                while (txd === 1'b0 && it < 40 * TP) begin
                    if (tick) low_ticks++;
                    @(negedge clk);
                    it++;
                    if (hold && it == 5) begin wr_data = val; wr_en = 1'b1; end
                    if (it == 6) wr_en = 1'b0;
                    if (len == 3 && it == 10) brk_clr = 1'b1;
                    if (it == 11) brk_clr = 1'b0;
                end
                chk($sformatf("R7 low ticks len=%0d", len), low_ticks, 13 + len);
                chk("R8 brk_active self-cleared", int'(brk_active), 0);
                if (hold) chk("R12 held during break", int'(tx_empty), 0);
                hi_ticks = 0;
                it = 0;
                if (hold) begin
                    while (txd === 1'b1 && it < 10 * TP) begin
                        if (tick) hi_ticks++;
                        @(negedge clk);
                        it++;
                    end
                    chk($sformatf("R10 stop ticks before held byte two=%0d", two), hi_ticks, 1 + two);
                    check_frame(val, 1'b0, 1'b0, two[0], 1'b0, 1'b0, 8'h00);
                end else begin
                    while (busy === 1'b1 && it < 10 * TP) begin
                        if (tick) begin
                            hi_ticks++;
                            chk("R9 stop level high", int'(txd), 1);
                        end
                        @(negedge clk);
                        it++;
                    end
                    chk($sformatf("R9 stop ticks two=%0d", two), hi_ticks, 1 + two);
                end
                repeat (3) @(negedge clk);
                chk("R11 one done pulse", done_seen, 1);
                chk("R1 idle after timed break", int'(txd), 1);
            end
        end
        report();
    end
endmodule